// File: doc/BRIEF.md
# ALU Status Flag Register

This block produces the status byte that follows each 8-bit ALU operation. It receives the two operands, the carry-in, the result the datapath has already formed, and an operation class. From these it derives sign, zero, half-carry, parity and carry. When the write enable is high, it stores them in a register whose byte layout is fixed.

The carry and half-carry are rebuilt from the operands, because the result alone does not contain them. Sign, zero and parity are read from the result that is supplied. The datapath, decimal adjustment and any software access to the register are outside this block.

The operation class encoding is 2'b00 add, 2'b01 subtract, and 2'b10 or 2'b11 logical.

Top module: `alu_flag_gen`

## Requirements
- R1: The flag byte has sign in bit 7, zero in bit 6, half-carry in bit 4, parity in bit 2 and carry in bit 0. Bits 5 and 3 always read 0 and bit 1 always reads 1.
- R2: After a write, the zero flag is 1 exactly when all 8 bits of the result are 0.
- R3: After a write, the sign flag equals bit 7 of the result.
- R4: After a write, the parity flag is 1 when the result holds an even number of 1 bits, and 0 otherwise.
- R5: For an add (class 2'b00), carry is 1 when A + B + carry-in exceeds 255.
- R6: For an add, half-carry is 1 when the low nibbles plus carry-in exceed 15, which is a carry out of bit 3.
- R7: For a subtract (class 2'b01), carry is 1 when A < B + carry-in, which is a borrow out of bit 7. Half-carry is 1 when the low nibble of A is less than the low nibble of B plus carry-in, which is a borrow out of bit 3.
- R8: For a logical class (2'b10 or 2'b11), carry and half-carry are written as 0, while zero, sign and parity are still taken from the result.
- R9: When the write enable is low at a clock edge, the flag byte keeps its value.
- R10: When the active-low reset is low at a clock edge, all five status flags clear and the byte reads 8'h02, whatever the write enable is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand (the subtrahend for subtract) |
| carry_in | input | 1 | Carry-in, or borrow-in for subtract |
| alu_res | input | 8 | Result from the datapath |
| op_class | input | 2 | 00 add, 01 subtract, 1x logical |
| flag_we | input | 1 | Write enable for the flag register |
| flag_byte | output | 8 | Registered flag byte |

## Verification
The embedded assertions check these behaviours on every cycle:
- the fixed constant bits;
- the reset value;
- holding the byte while the write enable is low;
- zero, sign and parity following the previous result;
- carry and half-carry cleared on logical writes.

The arithmetic meaning of carry and half-carry is shown only by the bench's scenarios. These are the nibble and byte boundaries for add and subtract, with and without carry-in, plus a stream of pseudo-random operands compared against an integer model. The same applies to the interaction of reset with a pending write.

// File: rtl/alu_flag_pkg.sv
// Package: shared types and bit positions for the ALU flag register.
// Assumes an 8-bit datapath; positions are fixed because consumers decode them.
package alu_flag_pkg;
    localparam int DATA_W   = 8;
    localparam int NIB_W    = 4;

    localparam int POS_SIGN = 7;
    localparam int POS_ZERO = 6;
    localparam int POS_HALF = 4;
    localparam int POS_PAR  = 2;
    localparam int POS_CARY = 0;

    // Constant bits: 5 and 3 read 0, bit 1 reads 1.
    localparam logic [DATA_W-1:0] FIXED_BITS = 8'h02;

    typedef enum logic [1:0] {
        OPC_ADD = 2'b00,
        OPC_SUB = 2'b01,
        OPC_LG0 = 2'b10,
        OPC_LG1 = 2'b11
    } op_class_t;

    typedef struct packed {
        logic sign;
        logic zero;
        logic half;
        logic par;
        logic cary;
    } stat_t;
endpackage

// File: rtl/aflg_carry_unit.sv
// Module: derives carry and half-carry from the operands.
// Assumes: subtract means A - B - carry_in; logical classes produce no carry.
module aflg_carry_unit
    import alu_flag_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int NW = NIB_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic [1:0]   opc,
    output logic         cary,
    output logic         half
);
    logic [W:0]  full_add, full_sub;
    logic [NW:0] nib_add, nib_sub;

    // Widened add and subtract; the top bit is the carry or the borrow.
    always_comb begin
        full_add = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        full_sub = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
        nib_add  = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
        nib_sub  = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - {{NW{1'b0}}, cin};
    end

    // Select by operation class.
    always_comb begin
        unique case (opc)
            OPC_ADD: begin cary = full_add[W]; half = nib_add[NW]; end
            OPC_SUB: begin cary = full_sub[W]; half = nib_sub[NW]; end
            default: begin cary = 1'b0;        half = 1'b0;        end
        endcase
    end
endmodule

// File: rtl/aflg_result_test.sv
// Module: zero, sign and even-parity tests on the supplied result.
// Assumes: the result is the final value for the operation.
module aflg_result_test
    import alu_flag_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] res,
    output logic         zero,
    output logic         sign,
    output logic         par
);
    logic [W:0] par_chain;

    // Parity as a ripple XOR chain, one stage per result bit.
    assign par_chain[0] = 1'b0;
    for (genvar i = 0; i < W; i++) begin : g_par
        assign par_chain[i+1] = par_chain[i] ^ res[i];
    end

    // Flags taken from the result.
    always_comb begin
        zero = (res == '0);
        sign = res[W-1];
        par  = ~par_chain[W];
    end
endmodule

// File: rtl/aflg_flag_reg.sv
// Module: storage for the five status flags.
// Assumes: synchronous active-low reset that wins over the write enable.
module aflg_flag_reg
    import alu_flag_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  stat_t d,
    output stat_t q
);
    // Capture new flags on write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= d;
    end
endmodule

// File: rtl/alu_flag_gen.sv
// Module: top of the ALU status flag register.
// Computes flags from operands and result, stores them on write,
// and presents them in a fixed byte layout with constant padding bits.
module alu_flag_gen
    import alu_flag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] opnd_a,
    input  logic [7:0] opnd_b,
    input  logic       carry_in,
    input  logic [7:0] alu_res,
    input  logic [1:0] op_class,
    input  logic       flag_we,
    output logic [7:0] flag_byte
);
    stat_t nxt, cur;

    aflg_carry_unit #(.W(DATA_W), .NW(NIB_W)) u_carry (
        .a(opnd_a), .b(opnd_b), .cin(carry_in), .opc(op_class),
        .cary(nxt.cary), .half(nxt.half)
    );

    aflg_result_test #(.W(DATA_W)) u_rtest (
        .res(alu_res), .zero(nxt.zero), .sign(nxt.sign), .par(nxt.par)
    );

    aflg_flag_reg u_reg (
        .clk(clk), .rst_n(rst_n), .we(flag_we), .d(nxt), .q(cur)
    );

    // Place the stored flags over the constant background.
    always_comb begin
        flag_byte           = FIXED_BITS;
        flag_byte[POS_SIGN] = cur.sign;
        flag_byte[POS_ZERO] = cur.zero;
        flag_byte[POS_HALF] = cur.half;
        flag_byte[POS_PAR]  = cur.par;
        flag_byte[POS_CARY] = cur.cary;
    end

    // R10
    reset_value_chk: assert property (@(posedge clk)
        !rst_n |=> flag_byte == 8'h02);

    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable(flag_byte));

    // R2
    zero_follows_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> flag_byte[6] == ($past(alu_res) == 8'h00));

    // R3
    sign_follows_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> flag_byte[7] == $past(alu_res[7]));

    // R4
    parity_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> flag_byte[2] == ($countones($past(alu_res)) % 2 == 0));

    // R8
    logic_no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op_class[1]) |=> (flag_byte[0] == 1'b0 && flag_byte[4] == 1'b0));

    // R1
    fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (flag_byte[5] == 1'b0 && flag_byte[3] == 1'b0 && flag_byte[1] == 1'b1));
endmodule

// File: tb/alu_flag_gen_tb.sv
module alu_flag_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opnd_a = '0, opnd_b = '0, alu_res = '0;
    logic       carry_in = 1'b0, flag_we = 1'b0;
    logic [1:0] op_class = '0;
    logic [7:0] flag_byte;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_byte = 8'h02;
    bit done = 0;

    always #2 clk = ~clk;

    alu_flag_gen u_dut (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .carry_in(carry_in), .alu_res(alu_res), .op_class(op_class),
        .flag_we(flag_we), .flag_byte(flag_byte)
    );

    task automatic chk_bit(input string tag, input int pos);
        checks++;
        if (flag_byte[pos] !== exp_byte[pos]) begin
            fails++;
            $display("FAIL %s bit%0d actual=%b expected=%b", tag, pos, flag_byte[pos], exp_byte[pos]);
        end
    endtask

    // Compare every field of the byte against the model.
    task automatic compare_all();
        chk_bit("R1 bit5", 5);
        chk_bit("R1 bit3", 3);
        chk_bit("R1 bit1", 1);
        chk_bit("R2 zero", 6);
        chk_bit("R3 sign", 7);
        chk_bit("R4 parity", 2);
        chk_bit("R5/R7/R8/R9 carry", 0);
        chk_bit("R6/R7/R8/R9 half", 4);
    endtask

    // Behavioural model of one clock edge.
    task automatic model_edge();
        int a, b, c, r, ones;
        bit cy, hc;
        a = opnd_a; b = opnd_b; c = carry_in; r = alu_res;
        if (!rst_n) begin
            exp_byte = 8'h02;
        end else if (flag_we) begin
            ones = 0;
            for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
            if (op_class == 2'b00) begin
                cy = (a + b + c) > 255;
                hc = ((a % 16) + (b % 16) + c) > 15;
            end else if (op_class == 2'b01) begin
                cy = a < (b + c);
                hc = (a % 16) < ((b % 16) + c);
            end else begin
                cy = 0; hc = 0;
            end
            exp_byte = 8'h02;
            exp_byte[7] = (r >= 128);
            exp_byte[6] = (r == 0);
            exp_byte[4] = hc;
            exp_byte[2] = (ones % 2 == 0);
            exp_byte[0] = cy;
        end
    endtask

    // Drive at negedge, model at posedge, compare at next negedge.
    task automatic step(input logic [1:0] opc, input logic [7:0] a, input logic [7:0] b,
                        input logic ci, input logic [7:0] r, input logic we);
        op_class = opc; opnd_a = a; opnd_b = b; carry_in = ci; alu_res = r; flag_we = we;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #800000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        rst_n = 1'b0; flag_we = 1'b1; alu_res = 8'h00;
        @(posedge clk); model_edge(); @(negedge clk);
        @(posedge clk); model_edge(); @(negedge clk);
        compare_all();                                  // R10 reset value
        rst_n = 1'b1;
        // R5 R6 add boundaries
        step(2'b00, 8'h0F, 8'h01, 1'b0, 8'h10, 1'b1);
        step(2'b00, 8'hFF, 8'h01, 1'b0, 8'h00, 1'b1);
        step(2'b00, 8'h0E, 8'h01, 1'b1, 8'h10, 1'b1);
        step(2'b00, 8'h7F, 8'h80, 1'b0, 8'hFF, 1'b1);
        step(2'b00, 8'hFF, 8'h00, 1'b1, 8'h00, 1'b1);
        // R7 subtract borrows
        step(2'b01, 8'h10, 8'h01, 1'b0, 8'h0F, 1'b1);
        step(2'b01, 8'h00, 8'h01, 1'b0, 8'hFF, 1'b1);
        step(2'b01, 8'h05, 8'h05, 1'b0, 8'h00, 1'b1);
        step(2'b01, 8'h05, 8'h05, 1'b1, 8'hFF, 1'b1);
        // R8 logical clears carry and half
        step(2'b00, 8'hFF, 8'hFF, 1'b1, 8'hFF, 1'b1);
        step(2'b10, 8'hFF, 8'hFF, 1'b1, 8'h81, 1'b1);
        step(2'b00, 8'hFF, 8'hFF, 1'b1, 8'hFF, 1'b1);
        step(2'b11, 8'hFF, 8'hFF, 1'b1, 8'h00, 1'b1);
        // R9 write enable low holds
        step(2'b00, 8'hFF, 8'h01, 1'b0, 8'h00, 1'b1);
        step(2'b10, 8'h00, 8'h00, 1'b0, 8'h7E, 1'b0);
        step(2'b01, 8'h00, 8'hFF, 1'b1, 8'h01, 1'b0);
        // R4 parity patterns
        step(2'b10, 8'h00, 8'h00, 1'b0, 8'h01, 1'b1);
        step(2'b10, 8'h00, 8'h00, 1'b0, 8'h03, 1'b1);
        // R10 reset wins over pending write
        step(2'b00, 8'hFF, 8'hFF, 1'b1, 8'hFF, 1'b1);
        rst_n = 1'b0;
        step(2'b00, 8'hFF, 8'hFF, 1'b1, 8'hFF, 1'b1);
        rst_n = 1'b1;
        // Pseudo-random stream against the model
        for (int n = 0; n < 400; n++) begin
            logic [7:0] ra, rb, rr;
            logic [1:0] ro;
            ra = 8'($urandom); rb = 8'($urandom); ro = 2'($urandom);
            rr = (ro == 2'b00) ? ra + rb : (ro == 2'b01) ? ra - rb : (ra & rb);
            step(ro, ra, rb, 1'($urandom), rr, 1'($urandom % 4 != 0));
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule